// File: doc/BRIEF.md
# Bad-Block Skipping Page Loader

This block sequences the copy of a run of consecutive flash pages into a destination memory. Software or a boot controller hands it a byte offset, a count of good pages wanted, the page size, the block size in pages and a destination base address, then pulses `start`. The loader walks page numbers upward from the page holding the offset. It relies on two external engines, each reached through a request/acknowledge handshake. A spare-area reader streams the spare bytes of a page. A chunk engine moves one 512-byte slice of page data into memory and runs error correction on it.

At the first page of every block the loader reads that page's spare area and looks at the block's bad-block marker. A bad block is stepped over as a whole and never counts toward the target. For every good page it issues one chunk request per 512-byte slice. Each request carries the column, the destination address and the spare-area offset where that slice's nine parity bytes live. The loader then moves its destination pointer on by one page and pulses a page-done strobe. It raises `done` once the requested number of good pages has been copied.

Top module: `bb_page_loader`

## Requirements
- R1: On an accepted `start`, the first page number is `start_offset >> page_shift`, where the page size is 2^`page_shift` bytes and `page_shift` is 9 to 12. The destination of the first copied page is `dest_base`.
- R2: A spare read (`sp_req`, with `sp_page` the current page) is issued before any chunk request of a page whose number is a multiple of 2^`blk_shift`. Pages that are not block starts get no spare read.
- R3: The marker is spare byte index 5 (counting `sp_valid` beats from 0) when `page_shift` is 9, and byte index 0 for every larger page. A marker value other than 8'hFF marks the block bad. All other spare bytes have no effect.
- R4: For a bad block, the page number advances by 2^`blk_shift` and the block gets no chunk requests. The destination address and the good-page count stay unchanged. The new page is checked again as a block start.
- R5: A good page gets 2^(`page_shift`-9) chunk requests with chunk index i = 0, 1, ... in order. Each carries `ck_page` = the page, `ck_col` = i*512 and `ck_dest` = page destination + i*512.
- R6: Each chunk request gives `ck_par_off` = 6 + 9*i, the spare offset of that chunk's nine parity bytes.
- R7: During a spare read, `sp_len` equals the spare-area size, 2^(`page_shift`-5) bytes.
- R8: After the acknowledge of a page's last chunk, `pg_done` pulses for one cycle. The destination address grows by the page size, and the next page is the following page number.
- R9: When the good-page count reaches `page_target`, the loader returns idle with `done` high and `busy` low. With `page_target` 0, `done` is high two cycles after `start` and no request is made. An accepted `start` clears `done` one cycle later.
- R10: A `start` pulse while `busy` is high has no effect. The run goes on with its latched offset, target, sizes and base, even if those inputs change.
- R11: `sp_req` and `ck_req` are never high together. A request and its fields stay stable until its acknowledge.
- R12: After reset the loader is idle, with `busy`, `done`, `sp_req`, `ck_req` and `pg_done` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, accepted only when idle |
| start_offset | input | OFFS_W | Byte offset of the first page |
| page_target | input | CNT_W | Number of good pages to copy |
| page_shift | input | SHIFT_W | log2 of page size in bytes (9..12) |
| blk_shift | input | BSH_W | log2 of pages per block |
| dest_base | input | ADDR_W | Destination address of first page |
| sp_req | output | 1 | Spare-area read request |
| sp_page | output | PAGE_W | Page whose spare area is read |
| sp_len | output | SPL_W | Spare-area length in bytes |
| sp_valid | input | 1 | Spare byte strobe |
| sp_data | input | 8 | Spare byte value |
| sp_ack | input | 1 | Spare read finished |
| ck_req | output | 1 | Chunk copy/correct request |
| ck_page | output | PAGE_W | Page of the chunk |
| ck_col | output | COL_W | Byte column of chunk within page |
| ck_par_off | output | POFF_W | Spare offset of chunk parity bytes |
| ck_dest | output | ADDR_W | Destination address of chunk |
| ck_ack | input | 1 | Chunk finished |
| pg_done | output | 1 | One-cycle pulse per copied good page |
| busy | output | 1 | Run in progress |
| done | output | 1 | Target reached, held until next start |

## Verification
Request timing is set by the engines, so the bench does not wait fixed latencies for requests. It models both engines and checks each `sp_req` and `ck_req` at the first falling edge where it appears. Each request is compared against the next item the driver queued, and the bench answers after a chosen delay. The fixed latencies are checked by exact counts: `done` falls one cycle after an accepted `start`, and with a zero target it rises at the second falling edge. `pg_done` pulses are counted and compared with the target once `done` is seen. The queues must then be empty, which also catches a missing or extra request.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_SPARE,
      ST_JUDGE,
      ST_CHUNK,
      ST_PAGE_END
   } ldr_state_e;

   localparam int unsigned CHUNK_SHIFT = 9;
   localparam int unsigned SPARE_SHIFT = 5;
   localparam int unsigned PAR_BASE    = 6;
   localparam int unsigned PAR_BYTES   = 9;
   localparam int unsigned SMALL_SHIFT = 9;
   localparam int unsigned SMALL_MARK  = 5;
   localparam int unsigned LARGE_MARK  = 0;

endpackage

// File: rtl/ldr_pos_track.sv
module ldr_pos_track #(
   parameter int OFFS_W  = 32,
   parameter int PAGE_W  = 24,
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 16,
   parameter int SHIFT_W = 4,
   parameter int BSH_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [OFFS_W-1:0] ld_offset,
   input  logic [SHIFT_W-1:0] ld_shift,
   input  logic [ADDR_W-1:0] ld_base,
   input  logic [SHIFT_W-1:0] cfg_shift,
   input  logic [BSH_W-1:0]  cfg_bsh,
   input  logic              skip_blk,
   input  logic              adv_page,
   output logic [PAGE_W-1:0] page,
   output logic [ADDR_W-1:0] dest,
   output logic [CNT_W-1:0]  copied,
   output logic              blk_start
);

   localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [PAGE_W-1:0] ONE_P = {{(PAGE_W-1){1'b0}}, 1'b1};

   logic [OFFS_W-1:0] ofs_sh;
   logic [ADDR_W-1:0] pg_bytes;
   logic [PAGE_W-1:0] blk_pages;

   assign ofs_sh    = ld_offset >> ld_shift;
   assign pg_bytes  = ONE_A << cfg_shift;
   assign blk_pages = ONE_P << cfg_bsh;
   assign blk_start = ((page & (blk_pages - ONE_P)) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page   <= '0;
         dest   <= '0;
         copied <= '0;
      end else if (load) begin
         page   <= ofs_sh[PAGE_W-1:0];
         dest   <= ld_base;
         copied <= '0;
      end else if (skip_blk) begin
         page   <= page + blk_pages;
      end else if (adv_page) begin
         page   <= page + ONE_P;
         dest   <= dest + pg_bytes;
         copied <= copied + {{(CNT_W-1){1'b0}}, 1'b1};
      end
   end

   // R1: a load places the destination at the base and clears the count
   a_r1_load_base: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (copied == '0) && (dest == $past(ld_base)));

   // R4: a skipped block moves the page by one block and nothing else
   a_r4_skip_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      skip_blk |=> (page == $past(page) + $past(blk_pages)) && $stable(dest) && $stable(copied));

   // R8: a finished page advances destination by one page size
   a_r8_page_advance: assert property (@(posedge clk) disable iff (!rst_n)
      adv_page |=> (dest == $past(dest) + $past(pg_bytes)) && (page == $past(page) + ONE_P));

endmodule

// File: rtl/ldr_marker_chk.sv
module ldr_marker_chk
   import ldr_pkg::*;
#(
   parameter int SHIFT_W        = 4,
   parameter int SPL_W          = 8,
   parameter int MIN_PAGE_SHIFT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [SHIFT_W-1:0] cfg_shift,
   input  logic              sp_valid,
   input  logic [7:0]        sp_data,
   output logic              blk_bad
);

   logic [SPL_W-1:0] beat;
   logic [SPL_W-1:0] mark_pos;
   logic [7:0]       marker;

   generate
      if (MIN_PAGE_SHIFT > SMALL_SHIFT) begin : g_large_only
         assign mark_pos = SPL_W'(LARGE_MARK);
      end else begin : g_mixed
         assign mark_pos = (cfg_shift == SHIFT_W'(SMALL_SHIFT)) ? SPL_W'(SMALL_MARK)
                                                                 : SPL_W'(LARGE_MARK);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat   <= '0;
         marker <= 8'hFF;
      end else if (arm) begin
         beat   <= '0;
         marker <= 8'hFF;
      end else if (sp_valid) begin
         beat <= beat + {{(SPL_W-1){1'b0}}, 1'b1};
         if (beat == mark_pos) marker <= sp_data;
      end
   end

   assign blk_bad = (marker != 8'hFF);

   // R3: only the beat at the marker index may change the captured marker
   a_r3_marker_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && !(sp_valid && beat == mark_pos)) |=> $stable(marker));

endmodule

// File: rtl/ldr_chunk_seq.sv
module ldr_chunk_seq
   import ldr_pkg::*;
#(
   parameter int SHIFT_W        = 4,
   parameter int ADDR_W         = 32,
   parameter int MAX_PAGE_SHIFT = 12,
   parameter int POFF_W         = 8,
   parameter int CI_W           = 3,
   parameter int COL_W          = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              step,
   input  logic [SHIFT_W-1:0] cfg_shift,
   input  logic [ADDR_W-1:0] page_dest,
   output logic              last,
   output logic [COL_W-1:0]  col,
   output logic [POFF_W-1:0] par_off,
   output logic [ADDR_W-1:0] chunk_dest
);

   localparam int NCK_MAX = 1 << (MAX_PAGE_SHIFT - CHUNK_SHIFT);

   logic [CI_W-1:0]    idx;
   logic [SHIFT_W-1:0] csh;
   logic [31:0]        nck;
   logic [CI_W-1:0]    last_idx;
   logic [POFF_W-1:0]  off_tab [NCK_MAX];

   genvar gi;
   generate
      for (gi = 0; gi < NCK_MAX; gi++) begin : g_off
         assign off_tab[gi] = POFF_W'(PAR_BASE + PAR_BYTES * gi);
      end
   endgenerate

   assign csh      = cfg_shift - SHIFT_W'(CHUNK_SHIFT);
   assign nck      = 32'd1 << csh;
   assign last_idx = nck[CI_W-1:0] - {{(CI_W-1){1'b0}}, 1'b1};
   assign last     = (idx == last_idx);
   assign col      = {idx, {CHUNK_SHIFT{1'b0}}};
   assign par_off  = off_tab[idx];
   assign chunk_dest = page_dest + {{(ADDR_W-COL_W){1'b0}}, col};

   always_ff @(posedge clk) begin
      if (!rst_n || !active) idx <= '0;
      else if (step && !last) idx <= idx + {{(CI_W-1){1'b0}}, 1'b1};
   end

   // R5: chunks of a page are visited in rising order
   a_r5_chunk_order: assert property (@(posedge clk) disable iff (!rst_n)
      (active && step && !last) |=> (idx == $past(idx) + {{(CI_W-1){1'b0}}, 1'b1}));

   // R11: the chunk fields hold while waiting for an acknowledge
   a_r11_chunk_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !step) |=> (!active || ($stable(col) && $stable(par_off))));

endmodule

// File: rtl/bb_page_loader.sv
module bb_page_loader
   import ldr_pkg::*;
#(
   parameter int OFFS_W         = 32,
   parameter int PAGE_W         = 24,
   parameter int ADDR_W         = 32,
   parameter int CNT_W          = 16,
   parameter int SHIFT_W        = 4,
   parameter int BSH_W          = 4,
   parameter int MIN_PAGE_SHIFT = 9,
   parameter int MAX_PAGE_SHIFT = 12,
   parameter int POFF_W         = 8,
   parameter int COL_W          = MAX_PAGE_SHIFT,
   parameter int SPL_W          = MAX_PAGE_SHIFT - SPARE_SHIFT + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [OFFS_W-1:0]  start_offset,
   input  logic [CNT_W-1:0]   page_target,
   input  logic [SHIFT_W-1:0] page_shift,
   input  logic [BSH_W-1:0]   blk_shift,
   input  logic [ADDR_W-1:0]  dest_base,
   output logic               sp_req,
   output logic [PAGE_W-1:0]  sp_page,
   output logic [SPL_W-1:0]   sp_len,
   input  logic               sp_valid,
   input  logic [7:0]         sp_data,
   input  logic               sp_ack,
   output logic               ck_req,
   output logic [PAGE_W-1:0]  ck_page,
   output logic [COL_W-1:0]   ck_col,
   output logic [POFF_W-1:0]  ck_par_off,
   output logic [ADDR_W-1:0]  ck_dest,
   input  logic               ck_ack,
   output logic               pg_done,
   output logic               busy,
   output logic               done
);

   localparam int CI_W = MAX_PAGE_SHIFT - CHUNK_SHIFT;
   localparam int NCK_MAX = 1 << CI_W;

   generate
      if (MIN_PAGE_SHIFT < CHUNK_SHIFT || MAX_PAGE_SHIFT <= CHUNK_SHIFT) begin : g_bad_pg
         $error("page shift range must lie above the chunk size");
      end
      if (MIN_PAGE_SHIFT > MAX_PAGE_SHIFT) begin : g_bad_rng
         $error("page shift range is empty");
      end
      if (OFFS_W < PAGE_W) begin : g_bad_ofs
         $error("offset narrower than page number");
      end
      if (COL_W != MAX_PAGE_SHIFT) begin : g_bad_col
         $error("column width must match the largest page");
      end
      if ((PAR_BASE + PAR_BYTES * NCK_MAX) > (1 << POFF_W)) begin : g_bad_poff
         $error("parity offset width too small");
      end
      if ((1 << SHIFT_W) <= MAX_PAGE_SHIFT) begin : g_bad_sh
         $error("shift field too narrow");
      end
   endgenerate

   ldr_state_e          state, nxt;
   logic [SHIFT_W-1:0]  shift_q;
   logic [BSH_W-1:0]    bsh_q;
   logic [CNT_W-1:0]    tgt_q;
   logic                done_q;

   logic [PAGE_W-1:0]   page;
   logic [ADDR_W-1:0]   dest;
   logic [CNT_W-1:0]    copied;
   logic                blk_start;
   logic                blk_bad;
   logic                ck_last;

   logic load, skip_blk, adv_page, arm, reached;

   assign reached  = (copied == tgt_q);
   assign load     = (state == ST_IDLE) && start;
   assign skip_blk = (state == ST_JUDGE) && blk_bad;
   assign adv_page = (state == ST_PAGE_END);
   assign arm      = (state == ST_CHECK) && !reached && blk_start;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:     if (start) nxt = ST_CHECK;
         ST_CHECK:    if (reached) nxt = ST_IDLE;
                      else if (blk_start) nxt = ST_SPARE;
                      else nxt = ST_CHUNK;
         ST_SPARE:    if (sp_ack) nxt = ST_JUDGE;
         ST_JUDGE:    nxt = blk_bad ? ST_CHECK : ST_CHUNK;
         ST_CHUNK:    if (ck_ack && ck_last) nxt = ST_PAGE_END;
         ST_PAGE_END: nxt = ST_CHECK;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         shift_q <= SHIFT_W'(MIN_PAGE_SHIFT);
         bsh_q   <= '0;
         tgt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state <= nxt;
         if (load) begin
            shift_q <= page_shift;
            bsh_q   <= blk_shift;
            tgt_q   <= page_target;
            done_q  <= 1'b0;
         end else if (state == ST_CHECK && reached) begin
            done_q  <= 1'b1;
         end
      end
   end

   ldr_pos_track #(
      .OFFS_W(OFFS_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W),
      .CNT_W(CNT_W), .SHIFT_W(SHIFT_W), .BSH_W(BSH_W)
   ) u_pos (
      .clk(clk), .rst_n(rst_n), .load(load),
      .ld_offset(start_offset), .ld_shift(page_shift), .ld_base(dest_base),
      .cfg_shift(shift_q), .cfg_bsh(bsh_q),
      .skip_blk(skip_blk), .adv_page(adv_page),
      .page(page), .dest(dest), .copied(copied), .blk_start(blk_start)
   );

   ldr_marker_chk #(
      .SHIFT_W(SHIFT_W), .SPL_W(SPL_W), .MIN_PAGE_SHIFT(MIN_PAGE_SHIFT)
   ) u_mark (
      .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_shift(shift_q),
      .sp_valid(sp_valid && state == ST_SPARE), .sp_data(sp_data),
      .blk_bad(blk_bad)
   );

   ldr_chunk_seq #(
      .SHIFT_W(SHIFT_W), .ADDR_W(ADDR_W), .MAX_PAGE_SHIFT(MAX_PAGE_SHIFT),
      .POFF_W(POFF_W), .CI_W(CI_W), .COL_W(COL_W)
   ) u_chunk (
      .clk(clk), .rst_n(rst_n), .active(state == ST_CHUNK),
      .step(ck_ack), .cfg_shift(shift_q), .page_dest(dest),
      .last(ck_last), .col(ck_col), .par_off(ck_par_off), .chunk_dest(ck_dest)
   );

   assign sp_req  = (state == ST_SPARE);
   assign sp_page = page;
   assign sp_len  = {{(SPL_W-1){1'b0}}, 1'b1} << (shift_q - SHIFT_W'(SPARE_SHIFT));
   assign ck_req  = (state == ST_CHUNK);
   assign ck_page = page;
   assign pg_done = adv_page;
   assign busy    = (state != ST_IDLE);
   assign done    = done_q;

   // R11: at most one engine is addressed at a time
   a_r11_one_req: assert property (@(posedge clk) disable iff (!rst_n)
      !(sp_req && ck_req));

   // R11: a spare request holds its page until acknowledged
   a_r11_spare_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_req && !sp_ack) |=> sp_req && $stable(sp_page));

   // R2: spare reads happen only on block-start pages
   a_r2_spare_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      sp_req |-> blk_start);

   // R9: done implies the target count was reached
   a_r9_done_count: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !busy) |-> (copied == tgt_q));

   // R10: a start during a run leaves the latched setup untouched
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(tgt_q) && $stable(shift_q) && $stable(bsh_q));

endmodule

// File: tb/tb_bb_page_loader.sv
module tb_bb_page_loader;

   typedef struct packed {
      logic [23:0] page;
      logic [11:0] col;
      logic [7:0]  poff;
      logic [31:0] dest;
   } ck_item_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [31:0] start_offset;
   logic [15:0] page_target;
   logic [3:0]  page_shift;
   logic [3:0]  blk_shift;
   logic [31:0] dest_base;
   logic        sp_req;
   logic [23:0] sp_page;
   logic [7:0]  sp_len;
   logic        sp_valid;
   logic [7:0]  sp_data;
   logic        sp_ack;
   logic        ck_req;
   logic [23:0] ck_page;
   logic [11:0] ck_col;
   logic [7:0]  ck_par_off;
   logic [31:0] ck_dest;
   logic        ck_ack;
   logic        pg_done;
   logic        busy;
   logic        done;

   int          n_vec = 0;
   int          n_bad = 0;
   int          pg_cnt = 0;
   int          cur_sh = 9;
   int          cur_bsh = 0;
   logic [63:0] bad_map = '0;
   logic [23:0] exp_sp[$];
   ck_item_t    exp_ck[$];
   bit          finished = 0;

   always #5 clk = ~clk;

   bb_page_loader dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
      .page_target(page_target), .page_shift(page_shift), .blk_shift(blk_shift),
      .dest_base(dest_base), .sp_req(sp_req), .sp_page(sp_page), .sp_len(sp_len),
      .sp_valid(sp_valid), .sp_data(sp_data), .sp_ack(sp_ack), .ck_req(ck_req),
      .ck_page(ck_page), .ck_col(ck_col), .ck_par_off(ck_par_off), .ck_dest(ck_dest),
      .ck_ack(ck_ack), .pg_done(pg_done), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) if (pg_done === 1'b1) pg_cnt++;

   // spare-area engine model (R2, R3, R7)
   initial begin
      sp_valid = 0; sp_data = 0; sp_ack = 0;
      forever begin
         @(negedge clk);
         if (sp_req === 1'b1) begin
            automatic logic [23:0] pg = sp_page;
            automatic int mpos = (cur_sh == 9) ? 5 : 0;
            automatic bit bad = bad_map[6'(pg >> cur_bsh)];
            if (exp_sp.size() == 0) chk(0, "R2 unexpected spare read", pg, 0);
            else begin
               automatic logic [23:0] e = exp_sp.pop_front();
               chk(pg == e, "R2 spare page", pg, e);
            end
            chk(sp_len == 8'(1 << (cur_sh - 5)), "R7 spare length", sp_len, 1 << (cur_sh - 5));
            repeat (2) @(negedge clk);
            for (int b = 0; b < (1 << (cur_sh - 5)); b++) begin
               sp_valid = 1;
               sp_data  = (b == mpos) ? (bad ? 8'hFE : 8'hFF) : 8'h00;
               @(negedge clk);
            end
            sp_valid = 0;
            sp_ack = 1;
            @(negedge clk);
            sp_ack = 0;
         end
      end
   end

   // chunk engine model and scoreboard monitor (R5, R6, R11)
   initial begin
      ck_ack = 0;
      forever begin
         @(negedge clk);
         if (ck_req === 1'b1) begin
            automatic ck_item_t got = {ck_page, ck_col, ck_par_off, ck_dest};
            chk(sp_req == 0, "R11 both requests high", sp_req, 0);
            if (exp_ck.size() == 0) chk(0, "R4 unexpected chunk", got, 0);
            else begin
               automatic ck_item_t e = exp_ck.pop_front();
               chk(got.page == e.page && got.col == e.col && got.dest == e.dest,
                   "R5 chunk page/col/dest", got, e);
               chk(got.poff == e.poff, "R6 parity offset", got.poff, e.poff);
            end
            @(negedge clk);
            chk({ck_req, ck_page, ck_col, ck_dest} == {1'b1, got.page, got.col, got.dest},
                "R11 chunk hold", {ck_page, ck_col}, {got.page, got.col});
            ck_ack = 1;
            @(negedge clk);
            ck_ack = 0;
         end
      end
   end

   task automatic model(input logic [31:0] ofs, input int tgt, input int sh,
                        input int bsh, input logic [31:0] base, input logic [63:0] bad);
      automatic int page = int'(ofs >> sh);
      automatic int copied = 0;
      automatic logic [31:0] d = base;
      while (copied < tgt) begin
         if ((page & ((1 << bsh) - 1)) == 0) begin
            exp_sp.push_back(24'(page));
            if (bad[6'(page >> bsh)]) begin
               page += (1 << bsh);
               continue;
            end
         end
         for (int i = 0; i < (1 << (sh - 9)); i++)
            exp_ck.push_back({24'(page), 12'(i * 512), 8'(6 + 9 * i), d + 32'(i * 512)});
         d += 32'(1 << sh);
         page++;
         copied++;
      end
   endtask

   task automatic run_case(input string tag, input logic [31:0] ofs, input int tgt,
                           input int sh, input int bsh, input logic [31:0] base,
                           input logic [63:0] bad, input bit restart);
      automatic int pg0;
      automatic int w;
      model(ofs, tgt, sh, bsh, base, bad);
      cur_sh = sh; cur_bsh = bsh; bad_map = bad;
      pg0 = pg_cnt;
      @(negedge clk);
      start = 1; start_offset = ofs; page_target = 16'(tgt);
      page_shift = 4'(sh); blk_shift = 4'(bsh); dest_base = base;
      @(negedge clk);
      start = 0;
      chk(done == 0, "R9 done cleared by start", done, 0);
      if (tgt == 0) begin
         @(negedge clk);
         chk(done == 1, "R9 zero target done", done, 1);
      end
      if (restart) begin
         repeat (5) @(negedge clk);
         chk(busy == 1, "R10 run still busy", busy, 1);
         start = 1; start_offset = 32'h0; page_target = 16'd1;
         page_shift = 4'd12; blk_shift = 4'd1; dest_base = 32'hDEAD_0000;
         @(negedge clk);
         start = 0;
      end
      w = 0;
      while (!(done === 1'b1 && busy === 1'b0) && w < 20000) begin
         @(negedge clk);
         w++;
      end
      @(negedge clk);
      $display("case %s finished", tag);
      chk(done == 1 && busy == 0, "R9 done and idle", {done, busy}, 2'b10);
      chk(pg_cnt - pg0 == tgt, "R8 page-done pulses", pg_cnt - pg0, tgt);
      chk(exp_sp.size() == 0, "R4 spare reads all seen", exp_sp.size(), 0);
      chk(exp_ck.size() == 0, "R1 chunk requests all seen", exp_ck.size(), 0);
      exp_sp.delete();
      exp_ck.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=0", 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0; start = 0; start_offset = 0; page_target = 0;
      page_shift = 4'd9; blk_shift = 0; dest_base = 0;
      repeat (3) @(negedge clk);
      chk({busy, done, sp_req, ck_req, pg_done} == 5'b0, "R12 reset state",
          {busy, done, sp_req, ck_req, pg_done}, 0);
      rst_n = 1;
      @(negedge clk);
      chk({busy, done, sp_req, ck_req} == 4'b0, "R12 idle after reset",
          {busy, done, sp_req, ck_req}, 0);
      // R1 R4: large pages, run crosses into a bad block
      run_case("big_pages", 32'h0001_F000, 5, 11, 6, 32'h1000_0000, 64'h2, 0);
      // R3: small pages, marker at index 5, block 0 bad
      run_case("small_pages", 32'h0, 3, 9, 5, 32'h2000_0000, 64'h1, 0);
      // R9: zero target
      run_case("zero_target", 32'h0, 0, 12, 4, 32'h3000_0000, 64'h0, 0);
      // R4: consecutive bad blocks, unaligned start
      run_case("two_bad", 32'd6144, 6, 11, 2, 32'h4000_0000, 64'h6, 0);
      // R10: restart attempt mid-run with changed inputs
      run_case("restart", 32'd5220, 4, 10, 3, 32'h8000_0000, 64'h2, 1);
      // R5 R6: largest page, all good
      run_case("max_page", 32'h0000_3000, 2, 12, 1, 32'h0, 64'h0, 0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule